// File: doc/BRIEF.md
# Indexed Effective Address Unit

This block turns a decoded indexed-addressing request into a final 16-bit effective address. A request names a mode, one of four base registers (two index registers and two stack pointers), and an indirection flag. It also carries the current register contents, the two 8-bit accumulators, the program counter and an offset that the operand fetcher has already collected. The block adds the right signed displacement to the right base. For the auto-stepping modes it also reports the new value of the base register for write-back.

When one level of indirection is requested, or the mode is the absolute-pointer mode, the computed address is treated as a pointer. The block then reads two bytes through a byte-wide memory port: the high byte at the pointer and the low byte at the pointer plus one. The word it reads becomes the final address, and no further level is followed. A one-cycle `done` strobe marks the cycle in which `ea` is valid. Combinations that have no meaning are refused with `illegal`, raised together with `done`.

Top module: `ixag_top`

## Requirements
- R1: `base_sel` picks the base register: 0 selects `reg_x`, 1 `reg_y`, 2 `reg_u`, 3 `reg_s`. Mode 0 (no offset) gives `ea` equal to the selected base.
- R2: Modes 1, 2 and 3 add a constant to the base. The constant is `offset[4:0]`, `offset[7:0]` or `offset[15:0]` respectively, read as signed, and offset bits above the used field are ignored.
- R3: Mode 4 adds `acc_a` sign-extended, mode 5 adds `acc_b` sign-extended, and mode 6 adds `{acc_a,acc_b}` as a signed 16-bit value.
- R4: Modes 7 and 8 (post-increment by 1 and by 2) give `ea` equal to the unmodified base. Write-back carries the base plus 1 or plus 2.
- R5: Modes 9 and 10 (pre-decrement by 1 and by 2) give the base minus 1 or minus 2 both as `ea` and as the write-back value.
- R6: Modes 11 and 12 add `offset[7:0]` or `offset[15:0]`, read as signed, to `pc`. The base register plays no part.
- R7: Mode 13 always reads the final address from memory at `offset`, whatever the state of `indirect`. Exactly two byte reads are made, with no second level.
- R8: With `indirect` set on a legal mode, the computed address is a pointer. The bytes at the pointer and at the pointer plus one form the high and low bytes of `ea`. `done` comes 4 cycles after the start cycle, against 1 cycle for a direct request.
- R9: Mode 1, 7 or 9 combined with `indirect`, and the undefined codes 14 and 15, are refused. `done` and `illegal` are raised one cycle after start, with no write-back and no memory read.
- R10: `wb_en` pulses for one cycle, the cycle after start, only for modes 7 to 10. `wb_sel` then equals `base_sel`. This holds with indirection too.
- R11: `done` is a single-cycle pulse per accepted request. A `start` that arrives while an indirection read is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 2 | Base register choice |
| indirect | input | 1 | Apply one level of indirection |
| reg_x | input | 16 | First index register |
| reg_y | input | 16 | Second index register |
| reg_u | input | 16 | User stack pointer |
| reg_s | input | 16 | System stack pointer |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc | input | 16 | Program counter |
| offset | input | 16 | Offset or absolute pointer |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| done | output | 1 | Final address valid |
| illegal | output | 1 | Request refused |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base register write-back strobe |
| wb_sel | output | 2 | Register to write back |
| wb_val | output | 16 | Write-back value |

## Verification
The bench uses negative accumulator and offset values, so an adder that zero-extends lands 256 or 65536 bytes away. It uses offsets with garbage above the used field, which catches a mode that reads too many bits. Post-increment and pre-decrement are checked on both `ea` and write-back, so swapping the pre and post address shows up at once. Indirection is checked for byte order, read count, latency and write-back. Refused combinations must show no memory read, and a start during a read must not produce a second `done`.

// File: rtl/ixag_pkg.sv
package ixag_pkg;
   typedef enum logic [3:0] {
      MD_ZERO  = 4'd0,  MD_OFF5  = 4'd1,  MD_OFF8  = 4'd2,  MD_OFF16 = 4'd3,
      MD_ACCA  = 4'd4,  MD_ACCB  = 4'd5,  MD_ACCD  = 4'd6,
      MD_INC1  = 4'd7,  MD_INC2  = 4'd8,  MD_DEC1  = 4'd9,  MD_DEC2  = 4'd10,
      MD_PC8   = 4'd11, MD_PC16  = 4'd12, MD_EXTIND = 4'd13,
      MD_RSV14 = 4'd14, MD_RSV15 = 4'd15
   } ix_mode_e;

   typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_LO, ST_FIN} ind_st_e;
endpackage

// File: rtl/ixag_base_mux.sv
module ixag_base_mux #(
   parameter int AW = 16,
   parameter int NREG = 4,
   localparam int SW = $clog2(NREG)
) (
   input  logic [NREG-1:0][AW-1:0] regs,
   input  logic [SW-1:0]           sel,
   output logic [AW-1:0]           base
);
   always_comb begin
      base = '0;
      for (int i = 0; i < NREG; i++)
         if (sel == SW'(i)) base = regs[i];
   end
endmodule

// File: rtl/ixag_addr_calc.sv
module ixag_addr_calc
   import ixag_pkg::*;
#(
   parameter int AW = 16,
   parameter int BW = 8,
   parameter bit PCREL_EN = 1'b1
) (
   input  ix_mode_e        mode,
   input  logic            ind_req,
   input  logic [AW-1:0]   base,
   input  logic [BW-1:0]   acc_a,
   input  logic [BW-1:0]   acc_b,
   input  logic [AW-1:0]   pc,
   input  logic [AW-1:0]   offset,
   output logic [AW-1:0]   addr,
   output logic            wb_en,
   output logic [AW-1:0]   wb_val,
   output logic            need_ind,
   output logic            illegal
);
   localparam int SHORT_W = 5;

   logic [AW-1:0] off5_x, off8_x, acca_x, accb_x, accd_x;
   logic [AW-1:0] pc_addr;
   logic          pc_mode, mode_bad;

   assign off5_x = {{(AW-SHORT_W){offset[SHORT_W-1]}}, offset[SHORT_W-1:0]};
   assign off8_x = {{(AW-BW){offset[BW-1]}}, offset[BW-1:0]};
   assign acca_x = {{(AW-BW){acc_a[BW-1]}}, acc_a};
   assign accb_x = {{(AW-BW){acc_b[BW-1]}}, acc_b};
   assign accd_x = {acc_a, acc_b};
   assign pc_mode = (mode == MD_PC8) || (mode == MD_PC16);

   generate
      if (PCREL_EN) begin : g_pcrel
         assign pc_addr  = pc + ((mode == MD_PC8) ? off8_x : offset);
         assign mode_bad = (mode == MD_RSV14) || (mode == MD_RSV15);
      end else begin : g_nopcrel
         assign pc_addr  = '0;
         assign mode_bad = (mode == MD_RSV14) || (mode == MD_RSV15) || pc_mode;
      end
   endgenerate

   always_comb begin
      addr   = base;
      wb_en  = 1'b0;
      wb_val = base;
      unique case (mode)
         MD_OFF5:   addr = base + off5_x;
         MD_OFF8:   addr = base + off8_x;
         MD_OFF16:  addr = base + offset;
         MD_ACCA:   addr = base + acca_x;
         MD_ACCB:   addr = base + accb_x;
         MD_ACCD:   addr = base + accd_x;
         MD_INC1:   begin wb_en = 1'b1; wb_val = base + AW'(1); end
         MD_INC2:   begin wb_en = 1'b1; wb_val = base + AW'(2); end
         MD_DEC1:   begin wb_en = 1'b1; wb_val = base - AW'(1); addr = wb_val; end
         MD_DEC2:   begin wb_en = 1'b1; wb_val = base - AW'(2); addr = wb_val; end
         MD_PC8, MD_PC16: addr = pc_addr;
         MD_EXTIND: addr = offset;
         default:   addr = base;
      endcase
      illegal = mode_bad ||
                (ind_req && (mode == MD_OFF5 || mode == MD_INC1 || mode == MD_DEC1));
      if (illegal) wb_en = 1'b0;
      need_ind = !illegal && (ind_req || mode == MD_EXTIND);
   end
endmodule

// File: rtl/ixag_ind_seq.sv
module ixag_ind_seq
   import ixag_pkg::*;
#(
   parameter int AW = 16,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] ptr,
   input  logic [BW-1:0] mem_rdata,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   output logic          busy,
   output logic          fin,
   output logic [AW-1:0] fin_addr
);
   ind_st_e       st;
   logic [AW-1:0] ptr_q;
   logic [BW-1:0] hi_q;

   assign mem_rd   = (st == ST_HI) || (st == ST_LO);
   assign mem_addr = (st == ST_LO) ? ptr_q + AW'(1) : ptr_q;
   assign busy     = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ptr_q    <= '0;
         hi_q     <= '0;
         fin      <= 1'b0;
         fin_addr <= '0;
      end else begin
         fin <= 1'b0;
         unique case (st)
            ST_IDLE: if (go) begin ptr_q <= ptr; st <= ST_HI; end
            ST_HI:   st <= ST_LO;
            ST_LO:   begin hi_q <= mem_rdata; st <= ST_FIN; end
            ST_FIN:  begin
               fin      <= 1'b1;
               fin_addr <= {hi_q, mem_rdata};
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   p_lo_follows_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HI) |=> (mem_rd && mem_addr == $past(mem_addr) + AW'(1)));
   p_fin_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FIN) |=> fin);
endmodule

// File: rtl/ixag_top.sv
module ixag_top
   import ixag_pkg::*;
#(
   parameter int AW = 16,
   parameter int BW = 8,
   parameter bit PCREL_EN = 1'b1,
   localparam int NREG = 4,
   localparam int SW = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [SW-1:0] base_sel,
   input  logic          indirect,
   input  logic [AW-1:0] reg_x,
   input  logic [AW-1:0] reg_y,
   input  logic [AW-1:0] reg_u,
   input  logic [AW-1:0] reg_s,
   input  logic [BW-1:0] acc_a,
   input  logic [BW-1:0] acc_b,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] offset,
   input  logic [BW-1:0] mem_rdata,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   output logic          done,
   output logic          illegal,
   output logic [AW-1:0] ea,
   output logic          wb_en,
   output logic [SW-1:0] wb_sel,
   output logic [AW-1:0] wb_val
);
   generate
      if (AW != 2 * BW) begin : g_bad_widths
         $error("ixag_top: AW must equal two bytes of BW");
      end
      if (BW < 8) begin : g_bad_byte
         $error("ixag_top: BW must be at least 8");
      end
   endgenerate

   logic [NREG-1:0][AW-1:0] regs;
   logic [AW-1:0] base, addr, c_wb_val, fin_addr;
   logic          c_wb_en, need_ind, c_illegal, busy, fin, accept;
   logic          done_q, illegal_q, wb_en_q;
   logic [AW-1:0] ea_q, wb_val_q;
   logic [SW-1:0] wb_sel_q;

   assign regs   = {reg_s, reg_u, reg_y, reg_x};
   assign accept = start && !busy;

   ixag_base_mux #(.AW(AW), .NREG(NREG)) u_base (
      .regs(regs), .sel(base_sel), .base(base));

   ixag_addr_calc #(.AW(AW), .BW(BW), .PCREL_EN(PCREL_EN)) u_calc (
      .mode(ix_mode_e'(mode)), .ind_req(indirect), .base(base),
      .acc_a(acc_a), .acc_b(acc_b), .pc(pc), .offset(offset),
      .addr(addr), .wb_en(c_wb_en), .wb_val(c_wb_val),
      .need_ind(need_ind), .illegal(c_illegal));

   ixag_ind_seq #(.AW(AW), .BW(BW)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(accept && need_ind), .ptr(addr),
      .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .busy(busy), .fin(fin), .fin_addr(fin_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         wb_en_q   <= 1'b0;
         ea_q      <= '0;
         wb_val_q  <= '0;
         wb_sel_q  <= '0;
      end else begin
         done_q    <= accept && !need_ind;
         illegal_q <= accept && c_illegal;
         wb_en_q   <= accept && c_wb_en;
         if (accept) begin
            ea_q     <= c_illegal ? '0 : addr;
            wb_val_q <= c_wb_val;
            wb_sel_q <= base_sel;
         end
      end
   end

   assign done    = done_q || fin;
   assign ea      = fin ? fin_addr : ea_q;
   assign illegal = illegal_q;
   assign wb_en   = wb_en_q;
   assign wb_sel  = wb_sel_q;
   assign wb_val  = wb_val_q;

   p_illegal_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (done && !wb_en && !mem_rd));
   p_wb_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(start));
   p_done_sources_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q && fin));
   p_busy_blocks_direct_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !done_q);
endmodule

// File: tb/ixag_top_tb.sv
module ixag_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [1:0]  base_sel = '0;
   logic        indirect = 1'b0;
   logic [15:0] reg_x = 16'h1200, reg_y = 16'h3400, reg_u = 16'h5600, reg_s = 16'h7800;
   logic [7:0]  acc_a = 8'hF0, acc_b = 8'h05;
   logic [15:0] pc = 16'hC000, offset = '0;
   logic [7:0]  mem_rdata = '0;
   logic        mem_rd, done, illegal, wb_en;
   logic [15:0] mem_addr, ea, wb_val;
   logic [1:0]  wb_sel;

   int n_chk = 0, n_err = 0;
   int lat, n_rd, n_wb, n_done;
   logic [15:0] got_ea, got_wb;
   logic [1:0]  got_sel;
   logic        got_ill;

   always #5 clk = ~clk;

   ixag_top u_dut (.*);

   function automatic logic [7:0] memf(input logic [15:0] a);
      return 8'(a[7:0] * 8'd37 + 8'd11);
   endfunction

   always_ff @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] m, input logic [1:0] s, input logic ind,
                      input logic [15:0] off);
      @(negedge clk);
      mode = m; base_sel = s; indirect = ind; offset = off; start = 1'b1;
      lat = 0; n_rd = 0; n_wb = 0; n_done = 0; got_ill = 0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         start = 1'b0;
         if (mem_rd) n_rd++;
         if (wb_en) begin n_wb++; got_wb = wb_val; got_sel = wb_sel; end
         if (done) begin
            n_done++;
            if (n_done == 1) begin lat = i; got_ea = ea; got_ill = illegal; end
         end
      end
   endtask

   task automatic t_reset;
      chk("R11 reset done", done, 0);
      chk("R10 reset wb_en", wb_en, 0);
      chk("R8 reset mem_rd", mem_rd, 0);
   endtask

   task automatic t_base;
      logic [15:0] exp [4];
      exp[0] = reg_x; exp[1] = reg_y; exp[2] = reg_u; exp[3] = reg_s;
      for (int s = 0; s < 4; s++) begin
         run(4'd0, 2'(s), 1'b0, 16'hFFFF);
         chk("R1 zero-offset ea", got_ea, exp[s]);
         chk("R1 latency", lat, 1);
         chk("R10 no write-back", n_wb, 0);
      end
   endtask

   task automatic t_const;
      run(4'd1, 2'd0, 1'b0, 16'h0010); chk("R2 off5 -16", got_ea, 16'h11F0);
      run(4'd1, 2'd0, 1'b0, 16'hABCF); chk("R2 off5 +15", got_ea, 16'h120F);
      run(4'd2, 2'd0, 1'b0, 16'h1280); chk("R2 off8 -128", got_ea, 16'h1180);
      run(4'd3, 2'd1, 1'b0, 16'h8000); chk("R2 off16", got_ea, 16'hB400);
   endtask

   task automatic t_acc;
      run(4'd4, 2'd2, 1'b0, 16'h0000); chk("R3 acc A", got_ea, 16'h55F0);
      run(4'd5, 2'd2, 1'b0, 16'h0000); chk("R3 acc B", got_ea, 16'h5605);
      run(4'd6, 2'd3, 1'b0, 16'h0000); chk("R3 acc D", got_ea, 16'h6805);
   endtask

   task automatic t_inc;
      run(4'd7, 2'd0, 1'b0, 16'h0); chk("R4 inc1 ea", got_ea, 16'h1200);
      chk("R4 inc1 wb", got_wb, 16'h1201); chk("R10 inc1 sel", got_sel, 0);
      chk("R10 wb once", n_wb, 1);
      run(4'd8, 2'd3, 1'b0, 16'h0); chk("R4 inc2 ea", got_ea, 16'h7800);
      chk("R4 inc2 wb", got_wb, 16'h7802); chk("R10 inc2 sel", got_sel, 3);
   endtask

   task automatic t_dec;
      run(4'd9, 2'd1, 1'b0, 16'h0); chk("R5 dec1 ea", got_ea, 16'h33FF);
      chk("R5 dec1 wb", got_wb, 16'h33FF);
      run(4'd10, 2'd2, 1'b0, 16'h0); chk("R5 dec2 ea", got_ea, 16'h55FE);
      chk("R5 dec2 wb", got_wb, 16'h55FE); chk("R10 dec2 sel", got_sel, 2);
   endtask

   task automatic t_pc;
      run(4'd11, 2'd1, 1'b0, 16'h12FE); chk("R6 pc8", got_ea, 16'hBFFE);
      run(4'd12, 2'd1, 1'b0, 16'h1234); chk("R6 pc16", got_ea, 16'hD234);
   endtask

   task automatic t_ext;
      run(4'd13, 2'd0, 1'b0, 16'h0040);
      chk("R7 ext ea", got_ea, {memf(16'h0040), memf(16'h0041)});
      chk("R7 two reads", n_rd, 2);
      chk("R7 latency", lat, 4);
      chk("R10 ext no wb", n_wb, 0);
   endtask

   task automatic t_ind;
      run(4'd2, 2'd0, 1'b1, 16'h0010);
      chk("R8 off8 ind ea", got_ea, {memf(16'h1210), memf(16'h1211)});
      chk("R8 latency", lat, 4);
      chk("R8 reads", n_rd, 2);
      run(4'd8, 2'd1, 1'b1, 16'h0);
      chk("R8 inc2 ind ea", got_ea, {memf(16'h3400), memf(16'h3401)});
      chk("R10 inc2 ind wb", got_wb, 16'h3402);
      run(4'd10, 2'd2, 1'b1, 16'h0);
      chk("R8 dec2 ind ea", got_ea, {memf(16'h55FE), memf(16'h55FF)});
      chk("R10 dec2 ind wb", got_wb, 16'h55FE);
   endtask

   task automatic t_illegal;
      logic [3:0] bad [4];
      logic       bi [4];
      bad[0] = 4'd1; bad[1] = 4'd7; bad[2] = 4'd9; bad[3] = 4'd14;
      bi[0] = 1; bi[1] = 1; bi[2] = 1; bi[3] = 0;
      for (int k = 0; k < 4; k++) begin
         run(bad[k], 2'd0, bi[k], 16'h0010);
         chk("R9 illegal flag", got_ill, 1);
         chk("R9 latency", lat, 1);
         chk("R9 no wb", n_wb, 0);
         chk("R9 no read", n_rd, 0);
      end
   endtask

   task automatic t_busy;
      @(negedge clk);
      mode = 4'd13; base_sel = 0; indirect = 0; offset = 16'h0022; start = 1'b1;
      n_done = 0; n_wb = 0;
      @(negedge clk);
      mode = 4'd7; start = 1'b1;
      for (int i = 2; i <= 9; i++) begin
         if (done) begin n_done++; got_ea = ea; end
         if (wb_en) n_wb++;
         @(negedge clk);
         start = 1'b0;
      end
      chk("R11 one done", n_done, 1);
      chk("R11 ea from first", got_ea, {memf(16'h0022), memf(16'h0023)});
      chk("R11 ignored start no wb", n_wb, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            t_base(); t_const(); t_acc(); t_inc(); t_dec();
            t_pc(); t_ext(); t_ind(); t_illegal(); t_busy();
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule